// File: doc/BRIEF.md
# Single-Precision Result Packer

This block takes a floating-point value in unpacked form and packs it into the 32-bit IEEE single-precision word. That word holds a sign bit, an 8-bit biased exponent and a 23-bit fraction. The unpacked value consists of a class code, a sign, a signed unbiased exponent, a 26-bit mantissa and a sticky bit. The mantissa carries the integer bit at the top and two extra bits (guard and round) at the bottom.

Zero, infinity and NaN are packed directly. Finite numbers go through one of two paths:
- the normal path, when the biased exponent is at least 1;
- the subnormal path, when it is 0 or less. This path shifts the mantissa right so that the leading one becomes an explicit fraction bit.

Both paths round under a 2-bit mode input and raise overflow, underflow and inexact flags. A trap-enable input makes an exact subnormal still report underflow.

Results are registered. Each accepted input produces one result word and one flag set on the next clock edge. The flags are also ORed into an accrued register, which a synchronous clear input resets.

Top module: `sp_result_packer`

## Requirements
- R1: Class code 0 is zero. It packs as the sign bit alone with every other bit clear, and raises no flag.
- R2: Class code 2 is infinity. It packs as the sign, exponent 255 and fraction 0, and raises no flag.
- R3: Class code 3 is NaN. It packs as the sign, exponent 255 and a fraction equal to mantissa bits 24..2, with fraction bit 22 (the quiet bit) forced to one. It raises no flag.
- R4: Class code 1 with exponent+127 ≥ 1 takes the normal path:
  - the fraction is the low 23 bits of the rounded value of mantissa bits 25..2, and the implied one is dropped;
  - mantissa bit 1 is guard, bit 0 is round, and the sticky input adds to what is discarded;
  - rounding mode 0 is nearest-even, 1 is toward zero, 2 is toward +infinity and 3 is toward -infinity;
  - inexact is raised when guard, round or sticky is set.
- R5: When rounding on the normal path carries the significand to 2.0, the exponent increases by one and the fraction is zero.
- R6: A final biased exponent of 255 or more raises overflow and inexact. The result is infinity in mode 0, in mode 2 for a positive sign and in mode 3 for a negative sign. Otherwise it is the largest finite value: exponent 254 with all fraction bits set.
- R7: Class code 1 with exponent+127 ≤ 0 takes the subnormal path:
  - the mantissa is shifted right by 1-(exponent+127) more places, and the shifted-out bits join sticky;
  - the result has exponent 0 and the rounded fraction;
  - underflow is raised when the result is inexact or when the trap enable is high.
- R8: When subnormal rounding reaches 2^23, the result becomes exponent 1 with fraction 0, and underflow and inexact are both raised.
- R9: outValid is high exactly in the cycle after inValid is sampled high. outWord and outFlags (bit 2 overflow, bit 1 underflow, bit 0 inexact) hold the result from that edge on.
- R10: accFlags ORs in the flags of every accepted input. accClear empties it on the next edge. If an input is accepted in the same cycle, that input's flags still enter the cleared register.
- R11: While reset is high and after it is released, outValid, outWord, outFlags and accFlags are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Accept the unpacked operand this cycle |
| inClass | input | 2 | 0 zero, 1 number, 2 infinity, 3 NaN |
| inSign | input | 1 | Sign of the operand |
| inExp | input | 10 | Signed unbiased exponent |
| inMant | input | 26 | Integer bit, 23 fraction bits, guard, round |
| inSticky | input | 1 | OR of bits below round |
| rndMode | input | 2 | Rounding mode |
| ufTrapEn | input | 1 | Underflow trap enable |
| accClear | input | 1 | Clear the accrued flags |
| outValid | output | 1 | Result is new this cycle |
| outWord | output | 32 | Packed single-precision word |
| outFlags | output | 3 | Overflow, underflow, inexact of this result |
| accFlags | output | 3 | Accrued flags, same bit order |

## Verification
Every result is due one clock edge after its operand is taken. The bench drives each operand on a falling edge with inValid high for one cycle. It then reads outValid, outWord and outFlags at the next falling edge, half a period after the register has loaded. The accrued flags change on that same edge, so the accrued checks sample them in that same window after each operand or clear. A separate check confirms that outValid has fallen one cycle later.

// File: rtl/sp_pack_pkg.sv
package sp_pack_pkg;
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int MANT_W  = FRAC_W + 3;            // integer bit + fraction + guard + round
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_TOP = (1 << EXP_W) - 1;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NUM  = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } fpClass_e;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'd0,
    RM_TOZERO  = 2'd1,
    RM_UP      = 2'd2,
    RM_DOWN    = 2'd3
  } rndMode_e;

  typedef struct packed {
    logic load;
    logic selZero;
    logic selInf;
    logic selNan;
    logic selSub;
    logic selNorm;
  } packStrobe_t;

  // Decide whether the kept significand is bumped by one ulp.
  function automatic logic roundUp(input rndMode_e mode, input logic sign,
                                   input logic lsb, input logic g,
                                   input logic r, input logic s);
    logic lostAny;
    lostAny = g | r | s;
    case (mode)
      RM_NEAREST: roundUp = g & (r | s | lsb);
      RM_TOZERO:  roundUp = 1'b0;
      RM_UP:      roundUp = lostAny & ~sign;
      default:    roundUp = lostAny & sign;
    endcase
  endfunction

  // On overflow: saturate to infinity (1) or to the largest finite value (0).
  function automatic logic overflowToInf(input rndMode_e mode, input logic sign);
    case (mode)
      RM_NEAREST: overflowToInf = 1'b1;
      RM_TOZERO:  overflowToInf = 1'b0;
      RM_UP:      overflowToInf = ~sign;
      default:    overflowToInf = sign;
    endcase
  endfunction
endpackage

// File: rtl/sp_pack_ctrl.sv
module sp_pack_ctrl
  import sp_pack_pkg::*;
#(
  parameter int EXPIN_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [1:0]         inClass,
  input  logic [EXPIN_W-1:0] inExp,
  input  logic               accClear,
  input  logic [2:0]         flagsNext,
  output packStrobe_t        strobe,
  output logic               outValid,
  output logic [2:0]         accFlags
);
  localparam logic signed [EXPIN_W:0] NEG_BIAS = -(EXPIN_W+1)'(BIAS);

  logic signed [EXPIN_W:0] expExt;
  logic isSub;
  fpClass_e cls;

  assign expExt = {inExp[EXPIN_W-1], inExp};
  assign isSub  = (expExt <= NEG_BIAS);
  assign cls    = fpClass_e'(inClass);

  always_comb begin
    strobe         = '0;
    strobe.load    = inValid;
    strobe.selZero = (cls == CLS_ZERO);
    strobe.selInf  = (cls == CLS_INF);
    strobe.selNan  = (cls == CLS_NAN);
    strobe.selSub  = (cls == CLS_NUM) &&  isSub;
    strobe.selNorm = (cls == CLS_NUM) && !isSub;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      accFlags <= '0;
    end else begin
      outValid <= inValid;
      accFlags <= (accClear ? 3'b000 : accFlags) | (inValid ? flagsNext : 3'b000);
    end
  end

  assert_valid_latency_R9: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  assert_valid_drop_R9: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
  assert_acc_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (accClear && !inValid) |=> (accFlags == 3'b000));
  assert_acc_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    !accClear |=> ((accFlags & $past(accFlags)) == $past(accFlags)));
endmodule

// File: rtl/sp_pack_datapath.sv
module sp_pack_datapath
  import sp_pack_pkg::*;
#(
  parameter int EXPIN_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  packStrobe_t        strobe,
  input  logic               inSign,
  input  logic [EXPIN_W-1:0] inExp,
  input  logic [MANT_W-1:0]  inMant,
  input  logic               inSticky,
  input  logic [1:0]         rndMode,
  input  logic               ufTrapEn,
  output logic [2:0]         flagsNext,
  output logic [WORD_W-1:0]  outWord,
  output logic [2:0]         outFlags
);
  localparam int BE_W = EXPIN_W + 2;
  localparam int SH_W = $clog2(MANT_W + 1);
  localparam logic signed [BE_W-1:0] BIAS_S    = BE_W'(BIAS);
  localparam logic signed [BE_W-1:0] ONE_S     = BE_W'(1);
  localparam logic signed [BE_W-1:0] MANT_W_S  = BE_W'(MANT_W);
  localparam logic signed [BE_W-1:0] EXP_TOP_S = BE_W'(EXP_TOP);
  localparam logic [EXP_W-1:0]  EXP_ONES  = '1;
  localparam logic [FRAC_W-1:0] FRAC_ONES = '1;
  localparam logic [FRAC_W-1:0] QUIET     = FRAC_W'(1) << (FRAC_W - 1);

  rndMode_e mode;
  logic signed [BE_W-1:0] biased, shRaw, expNorm;
  logic [SH_W-1:0]   shAmt;
  logic [MANT_W-1:0] shifted, lostMask;
  logic [FRAC_W:0]   keep;
  logic [FRAC_W+1:0] rounded;
  logic guardBit, roundBit, stickyAll, inexact, inc, carry, promote, ovf;
  logic [WORD_W-1:0] wordNext;

  assign mode   = rndMode_e'(rndMode);
  assign biased = {{2{inExp[EXPIN_W-1]}}, inExp} + BIAS_S;
  assign shRaw  = ONE_S - biased;

  // Right shift applies only on the subnormal path; clamp so all bits fall into sticky.
  always_comb begin
    if (!strobe.selSub)         shAmt = '0;
    else if (shRaw > MANT_W_S)  shAmt = SH_W'(MANT_W);
    else                        shAmt = shRaw[SH_W-1:0];
  end

  assign shifted   = inMant >> shAmt;
  assign lostMask  = ~({MANT_W{1'b1}} << shAmt);
  assign keep      = shifted[MANT_W-1:2];
  assign guardBit  = shifted[1];
  assign roundBit  = shifted[0];
  assign stickyAll = inSticky | (|(inMant & lostMask));
  assign inexact   = guardBit | roundBit | stickyAll;
  assign inc       = roundUp(mode, inSign, keep[0], guardBit, roundBit, stickyAll);
  assign rounded   = {1'b0, keep} + (FRAC_W+2)'(inc);
  assign carry     = rounded[FRAC_W+1];
  assign promote   = rounded[FRAC_W];
  assign expNorm   = biased + (carry ? ONE_S : '0);
  assign ovf       = (expNorm >= EXP_TOP_S);

  always_comb begin
    wordNext  = '0;
    flagsNext = 3'b000;
    if (strobe.selZero) begin
      wordNext = {inSign, {(WORD_W-1){1'b0}}};
    end else if (strobe.selInf) begin
      wordNext = {inSign, EXP_ONES, {FRAC_W{1'b0}}};
    end else if (strobe.selNan) begin
      wordNext = {inSign, EXP_ONES, inMant[MANT_W-2:2] | QUIET};
    end else if (strobe.selSub) begin
      if (promote) begin
        wordNext  = {inSign, EXP_W'(1), {FRAC_W{1'b0}}};
        flagsNext = 3'b011;
      end else begin
        wordNext  = {inSign, {EXP_W{1'b0}}, rounded[FRAC_W-1:0]};
        flagsNext = {1'b0, inexact | ufTrapEn, inexact};
      end
    end else if (strobe.selNorm) begin
      if (ovf) begin
        flagsNext = 3'b101;
        if (overflowToInf(mode, inSign))
          wordNext = {inSign, EXP_ONES, {FRAC_W{1'b0}}};
        else
          wordNext = {inSign, EXP_W'(EXP_TOP - 1), FRAC_ONES};
      end else begin
        wordNext  = {inSign, expNorm[EXP_W-1:0], rounded[FRAC_W-1:0]};
        flagsNext = {2'b00, inexact};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outWord  <= '0;
      outFlags <= '0;
    end else if (strobe.load) begin
      outWord  <= wordNext;
      outFlags <= flagsNext;
    end
  end

  assert_nan_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && strobe.selNan) |=>
      (outWord[FRAC_W-1] && (outWord[WORD_W-2:FRAC_W] == EXP_ONES) && outFlags == 3'b000));
  assert_ovf_inexact_R6: assert property (@(posedge clk) disable iff (rst)
    outFlags[2] |-> outFlags[0]);
  assert_sub_exp_R7: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && strobe.selSub) |=> (outWord[WORD_W-2:FRAC_W] <= EXP_W'(1)));
  assert_promote_R8: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && strobe.selSub) |=>
      (outWord[WORD_W-2:FRAC_W] != EXP_W'(1) ||
       (outWord[FRAC_W-1:0] == '0 && outFlags[1:0] == 2'b11)));
endmodule

// File: rtl/sp_result_packer.sv
module sp_result_packer
  import sp_pack_pkg::*;
#(
  parameter int EXPIN_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [1:0]         inClass,
  input  logic               inSign,
  input  logic [EXPIN_W-1:0] inExp,
  input  logic [MANT_W-1:0]  inMant,
  input  logic               inSticky,
  input  logic [1:0]         rndMode,
  input  logic               ufTrapEn,
  input  logic               accClear,
  output logic               outValid,
  output logic [WORD_W-1:0]  outWord,
  output logic [2:0]         outFlags,
  output logic [2:0]         accFlags
);
  packStrobe_t strobe;
  logic [2:0]  flagsNext;

  sp_pack_ctrl #(.EXPIN_W(EXPIN_W)) uCtrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inClass(inClass), .inExp(inExp),
    .accClear(accClear), .flagsNext(flagsNext), .strobe(strobe),
    .outValid(outValid), .accFlags(accFlags)
  );

  sp_pack_datapath #(.EXPIN_W(EXPIN_W)) uData (
    .clk(clk), .rst(rst), .strobe(strobe), .inSign(inSign), .inExp(inExp),
    .inMant(inMant), .inSticky(inSticky), .rndMode(rndMode), .ufTrapEn(ufTrapEn),
    .flagsNext(flagsNext), .outWord(outWord), .outFlags(outFlags)
  );
endmodule

// File: tb/sim_sp_result_packer.sv
module sim_sp_result_packer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [1:0] inClass = '0;
  logic inSign = 1'b0;
  logic [9:0] inExp = '0;
  logic [25:0] inMant = '0;
  logic inSticky = 1'b0;
  logic [1:0] rndMode = '0;
  logic ufTrapEn = 1'b0;
  logic accClear = 1'b0;
  logic outValid;
  logic [31:0] outWord;
  logic [2:0] outFlags, accFlags;

  int totalCnt = 0;
  int failCnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sp_result_packer u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inClass(inClass), .inSign(inSign),
    .inExp(inExp), .inMant(inMant), .inSticky(inSticky), .rndMode(rndMode),
    .ufTrapEn(ufTrapEn), .accClear(accClear), .outValid(outValid),
    .outWord(outWord), .outFlags(outFlags), .accFlags(accFlags)
  );

  logic [25:0] pats [12] = '{26'h2000000, 26'h3FFFFFF, 26'h2000002, 26'h2000006,
                             26'h2000001, 26'h2000003, 26'h2AAAAAA, 26'h3555555,
                             26'h3FFFFFE, 26'h3FFFFFD, 26'h2800000, 26'h3000004};

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    totalCnt++;
    if (got !== exp) begin
      failCnt++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  // Arithmetic reference: {flags, word}; tag names the rule that applies.
  function automatic logic [34:0] model(input int cls, input bit sign, input int e,
                                        input logic [25:0] m, input bit st,
                                        input int mode, input bit trap,
                                        output string tag);
    int be, tot;
    longint mv, keep, rem, half, rnd, one;
    bit nx, above, tie, up, toInf;
    logic [22:0] frac;
    one = 1;
    if (cls == 0) begin tag = "R1"; return {3'b000, sign, 31'd0}; end
    if (cls == 2) begin tag = "R2"; return {3'b000, sign, 8'hFF, 23'd0}; end
    if (cls == 3) begin tag = "R3"; return {3'b000, sign, 8'hFF, m[24:2] | 23'h400000}; end
    be = e + 127;
    tot = (be >= 1) ? 2 : 3 - be;
    if (tot > 60) tot = 60;
    mv   = longint'(m);
    keep = mv >> tot;
    rem  = mv - (keep << tot);
    half = one << (tot - 1);
    nx    = (rem != 0) || st;
    above = (rem > half) || (rem == half && st);
    tie   = (rem == half) && !st;
    case (mode)
      0: up = above || (tie && keep[0]);
      1: up = 0;
      2: up = nx && !sign;
      default: up = nx && sign;
    endcase
    rnd = keep + (up ? 1 : 0);
    if (be < 1) begin
      if (rnd == (one << 23)) begin tag = "R8"; return {3'b011, sign, 8'd1, 23'd0}; end
      tag = "R7";
      return {1'b0, nx || trap, nx, sign, 8'd0, rnd[22:0]};
    end
    tag = "R4";
    frac = rnd[22:0];
    if (rnd == (one << 24)) begin be++; frac = '0; tag = "R5"; end
    if (be >= 255) begin
      tag = "R6";
      toInf = (mode == 0) || (mode == 2 && !sign) || (mode == 3 && sign);
      if (toInf) return {3'b101, sign, 8'hFF, 23'd0};
      return {3'b101, sign, 8'hFE, 23'h7FFFFF};
    end
    return {2'b00, nx, sign, be[7:0], frac};
  endfunction

  task automatic runVec(input int cls, input bit sign, input int e, input logic [25:0] m,
                        input bit st, input int mode, input bit trap);
    logic [34:0] exp;
    string tag;
    exp = model(cls, sign, e, m, st, mode, trap, tag);
    inClass = 2'(cls); inSign = sign; inExp = 10'(e); inMant = m;
    inSticky = st; rndMode = 2'(mode); ufTrapEn = trap; inValid = 1'b1;
    @(posedge clk); @(negedge clk);
    inValid = 1'b0;
    check("R9 outValid", 64'(outValid), 64'd1);
    check(tag, 64'({outFlags, outWord}), 64'(exp));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      totalCnt++; failCnt++;
      $display("FAIL watchdog actual hung expected finish");
      $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: outputs clear under reset and right after release
    check("R11 reset", 64'({outValid, outWord, outFlags, accFlags}), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R11 after release", 64'({outValid, outWord, outFlags, accFlags}), 64'd0);

    // Special classes: R1, R2, R3
    for (int c = 0; c < 4; c++) begin
      if (c == 1) continue;
      for (int s = 0; s < 2; s++)
        for (int p = 0; p < 12; p++)
          runVec(c, s[0], 3, pats[p], p[0], p % 4, p[1]);
    end
    // Signalling NaN pattern (quiet bit clear on input) - R3
    runVec(3, 1'b0, 0, 26'h0000004, 1'b0, 0, 1'b0);

    // Numbers: R4 to R8 across modes, signs, exponents, mantissas, sticky and trap
    for (int mode = 0; mode < 4; mode++)
      for (int s = 0; s < 2; s++)
        for (int ei = 0; ei < 37; ei++)
          for (int p = 0; p < 12; p++)
            for (int st = 0; st < 2; st++)
              for (int tr = 0; tr < 2; tr++)
                runVec(1, s[0], (ei < 32) ? (-155 + ei) : (125 + ei - 32),
                       pats[p], st[0], mode, tr[0]);

    // R9: valid drops one cycle after a single accepted input
    @(negedge clk);
    check("R9 valid low", 64'(outValid), 64'd0);

    // R10: accrued flags
    accClear = 1'b1; @(posedge clk); @(negedge clk); accClear = 1'b0;
    check("R10 cleared", 64'(accFlags), 64'd0);
    runVec(1, 1'b0, 0, 26'h2000001, 1'b0, 0, 1'b0);          // inexact only
    check("R10 accrue nx", 64'(accFlags), 64'b001);
    runVec(1, 1'b0, 128, 26'h2000000, 1'b0, 1, 1'b0);        // overflow
    check("R10 accrue of", 64'(accFlags), 64'b101);
    runVec(1, 1'b0, 0, 26'h2000000, 1'b0, 0, 1'b0);          // exact normal
    check("R10 holds", 64'(accFlags), 64'b101);
    accClear = 1'b1; @(posedge clk); @(negedge clk); accClear = 1'b0;
    check("R10 clear alone", 64'(accFlags), 64'd0);
    accClear = 1'b1;
    runVec(1, 1'b0, -127, 26'h3FFFFFF, 1'b0, 0, 1'b0);       // promotes: uf+nx
    accClear = 1'b0;
    check("R10 clear with input", 64'(accFlags), 64'b011);

    done = 1;
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end
endmodule